// File: doc/BRIEF.md
# Polynomial Tabulator by Finite Differences

This block produces the values of a quadratic polynomial at consecutive integer arguments and uses only adders. It keeps three registers: the current value, the first difference that produced it, and a constant second difference. On each accepted step the first difference grows by the second difference, and the value then grows by the new first difference. A counter tracks the integer argument. After reset the block tabulates n*n + n + 41 from n = 0. A load strobe starts any other quadratic from a chosen value and chosen differences. A sticky flag reports that an addition has wrapped.

A parameter selects how the step arithmetic is built. In the chained variant, one adder forms the new first difference and a second adder feeds it into the value. In the fused variant, a single three-operand adder forms the value directly from the current value and both differences. The two variants give the same outputs on every cycle.

Top module: `poly_tab`

## Requirements
- R1: During and after a synchronous reset (`rst` high at a clock edge), value is 41, index is 0, valid is 0 and overflow is 0, and the stored first and second differences are 0 and 2.
- R2: valid goes to 1 at the first clock edge that sees neither reset nor load. It goes to 0 at every edge where reset or load is high, so it stays low for exactly one cycle after a single load pulse.
- R3: At an edge with step high, valid high, load low and reset low, the first difference becomes first difference plus second difference, the value becomes value plus that new first difference, and index increments by one, modulo 2^IDX_W.
- R4: From reset, stepping gives 41, 43, 47, 53, 61 for index 0 to 4, and the value equals index*index + index + 41 for at least 100 consecutive steps.
- R5: A step request at an edge where valid is low changes neither value nor index.
- R6: At an edge with step, load and reset all low, value, index and overflow keep their values.
- R7: Load has priority over step. At a load edge, value takes `load_value`, index becomes 0, overflow clears, and the differences take `load_diff1` (the difference that led to the loaded value) and `load_diff2`. The first following step therefore adds load_diff1 + load_diff2.
- R8: Values are WIDTH-bit unsigned and wrap modulo 2^WIDTH. overflow sets at a step where either the difference addition or the value addition carries out of bit WIDTH-1.
- R9: Once set, overflow stays set until the next reset or load.
- R10: The chained variant (FUSED_ADD = 0) and the fused variant (FUSED_ADD = 1) give identical value, index, valid and overflow on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load strobe; loads the start state and has priority over step |
| load_value | input | WIDTH | Value at index 0 after a load |
| load_diff1 | input | WIDTH | First difference that led to the loaded value |
| load_diff2 | input | WIDTH | Constant second difference after a load |
| step | input | 1 | Advance to the next integer argument |
| value | output | WIDTH | Polynomial value at the current index |
| index | output | IDX_W | Current integer argument |
| valid | output | 1 | Outputs are settled (low for one cycle after reset or load) |
| overflow | output | 1 | Sticky flag; set when an addition wraps |

## Verification
The bench builds two copies with WIDTH = 32 and IDX_W = 16: the default chained variant and the fused variant. Every cycle it compares both copies with a behavioural model and with each other. The default start state runs for more than 100 steps with idle gaps, so the value stays well below 2^32 there. With 32-bit data, the loads are what reach the carry cases. One load puts the value just below 2^32 so that the value addition wraps. Another load uses two differences whose sum carries by itself, so that only the difference addition wraps.

// File: rtl/poly_tab_pkg.sv
package poly_tab_pkg;
   // Variant selector for the step arithmetic
   localparam int unsigned ADD_CHAINED = 0;
   localparam int unsigned ADD_FUSED   = 1;

   // Number of extra sum bits a three-operand adder needs
   localparam int unsigned ADD3_GROWTH = 2;
endpackage

// File: rtl/poly_tab_add2.sv
module poly_tab_add2 #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         carry
);
   logic [W:0] full;

   always_comb begin
      full  = {1'b0, a} + {1'b0, b};
      sum   = full[W-1:0];
      carry = full[W];
   end
endmodule

// File: rtl/poly_tab_add3.sv
module poly_tab_add3 #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] sum,
   output logic         carry
);
   import poly_tab_pkg::*;
   localparam int unsigned SW = W + ADD3_GROWTH;
   logic [SW-1:0] full;

   always_comb begin
      full  = {{ADD3_GROWTH{1'b0}}, a} + {{ADD3_GROWTH{1'b0}}, b}
            + {{ADD3_GROWTH{1'b0}}, c};
      sum   = full[W-1:0];
      carry = |full[SW-1:W];
   end
endmodule

// File: rtl/poly_tab_seq.sv
module poly_tab_seq #(
   parameter int unsigned IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   output logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic             valid
);
   always_comb adv = step & valid & ~load;

   always_ff @(posedge clk) begin
      if (rst || load) begin
         idx   <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b1;
         if (adv) idx <= idx + 1'b1;
      end
   end

   AST_VALID_DROP: assert property (@(posedge clk) load |=> !valid); // R2
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
      (!load) |=> valid); // R2
   AST_IGNORE_INVALID: assert property (@(posedge clk) disable iff (rst)
      (!valid && !load) |=> (idx == $past(idx))); // R5
   AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (valid && step && !load) |=> (idx == $past(idx) + 1'b1)); // R3
endmodule

// File: rtl/poly_tab_core.sv
module poly_tab_core #(
   parameter int unsigned W         = 32,
   parameter logic [W-1:0] INIT_F   = 41,
   parameter logic [W-1:0] INIT_D1  = 0,
   parameter logic [W-1:0] INIT_D2  = 2,
   parameter int unsigned FUSED_ADD = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         adv,
   input  logic [W-1:0] ld_f,
   input  logic [W-1:0] ld_d1,
   input  logic [W-1:0] ld_d2,
   output logic [W-1:0] f_q,
   output logic         ovf_q
);
   import poly_tab_pkg::*;

   logic [W-1:0] d1_q, d2_q;
   logic [W-1:0] d1_nx, f_nx;
   logic         c_d, c_f;

   // New first difference: always a plain two-operand add
   poly_tab_add2 #(.W(W)) u_dadd (
      .a(d1_q), .b(d2_q), .sum(d1_nx), .carry(c_d));

   generate
      if (FUSED_ADD == ADD_FUSED) begin : g_fused
         poly_tab_add3 #(.W(W)) u_fadd (
            .a(f_q), .b(d1_q), .c(d2_q), .sum(f_nx), .carry(c_f));
      end else begin : g_chain
         poly_tab_add2 #(.W(W)) u_fadd (
            .a(f_q), .b(d1_nx), .sum(f_nx), .carry(c_f));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         f_q   <= INIT_F;
         d1_q  <= INIT_D1;
         d2_q  <= INIT_D2;
         ovf_q <= 1'b0;
      end else if (load) begin
         f_q   <= ld_f;
         d1_q  <= ld_d1;
         d2_q  <= ld_d2;
         ovf_q <= 1'b0;
      end else if (adv) begin
         f_q   <= f_nx;
         d1_q  <= d1_nx;
         ovf_q <= ovf_q | c_d | c_f;
      end
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      load |=> (f_q == $past(ld_f)) && !ovf_q); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!adv && !load) |=> $stable(f_q) && $stable(ovf_q)); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovf_q && !load) |=> ovf_q); // R9
   AST_D2_CONST: assert property (@(posedge clk) disable iff (rst)
      (!load) |=> $stable(d2_q)); // R3
endmodule

// File: rtl/poly_tab.sv
module poly_tab #(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned IDX_W     = 16,
   parameter logic [WIDTH-1:0] INIT_F  = 41,
   parameter logic [WIDTH-1:0] INIT_D1 = 0,
   parameter logic [WIDTH-1:0] INIT_D2 = 2,
   parameter int unsigned FUSED_ADD = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] load_value,
   input  logic [WIDTH-1:0] load_diff1,
   input  logic [WIDTH-1:0] load_diff2,
   input  logic             step,
   output logic [WIDTH-1:0] value,
   output logic [IDX_W-1:0] index,
   output logic             valid,
   output logic             overflow
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("poly_tab: WIDTH must be at least 2");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("poly_tab: IDX_W must be at least 1");
      end
      if (FUSED_ADD > 1) begin : g_bad_mode
         $error("poly_tab: FUSED_ADD must be 0 or 1");
      end
   endgenerate

   logic adv;

   poly_tab_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .adv(adv), .idx(index), .valid(valid));

   poly_tab_core #(
      .W(WIDTH), .INIT_F(INIT_F), .INIT_D1(INIT_D1),
      .INIT_D2(INIT_D2), .FUSED_ADD(FUSED_ADD)
   ) u_core (
      .clk(clk), .rst(rst), .load(load), .adv(adv),
      .ld_f(load_value), .ld_d1(load_diff1), .ld_d2(load_diff2),
      .f_q(value), .ovf_q(overflow));

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (index == '0) && !valid && !overflow); // R1
endmodule

// File: tb/poly_tab_tb_top.sv
module poly_tab_tb_top;
   localparam int W  = 32;
   localparam int IW = 16;
   localparam longint MOD  = 64'h1_0000_0000;
   localparam longint MASK = 64'hFFFF_FFFF;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load = 1'b0;
   logic step = 1'b0;
   logic [W-1:0] lv = '0, ld1 = '0, ld2 = '0;

   logic [W-1:0]  v_c, v_f;
   logic [IW-1:0] i_c, i_f;
   logic          val_c, val_f, o_c, o_f;

   always #4 clk = ~clk;   // 125 MHz

   poly_tab #(.WIDTH(W), .IDX_W(IW), .FUSED_ADD(0)) dut_i (
      .clk(clk), .rst(rst), .load(load), .load_value(lv),
      .load_diff1(ld1), .load_diff2(ld2), .step(step),
      .value(v_c), .index(i_c), .valid(val_c), .overflow(o_c));

   poly_tab #(.WIDTH(W), .IDX_W(IW), .FUSED_ADD(1)) dut_fused_i (
      .clk(clk), .rst(rst), .load(load), .load_value(lv),
      .load_diff1(ld1), .load_diff2(ld2), .step(step),
      .value(v_f), .index(i_f), .valid(val_f), .overflow(o_f));

   // Behavioural reference
   longint mf = 41, md1 = 0, md2 = 2, mn = 0;
   bit     mv = 0, mo = 0;
   int     n_checks = 0, n_fail = 0;
   string  tag = "R1";
   bit     default_run = 1'b1;

   always @(posedge clk) begin
      if (rst) begin
         mf = 41; md1 = 0; md2 = 2; mn = 0; mv = 0; mo = 0;
      end else if (load) begin
         mf = lv; md1 = ld1; md2 = ld2; mn = 0; mv = 0; mo = 0;
      end else begin
         if (step && mv) begin
            md1 = md1 + md2;
            if (md1 >= MOD) mo = 1;
            md1 = md1 & MASK;
            mf = mf + md1;
            if (mf >= MOD) mo = 1;
            mf = mf & MASK;
            mn = (mn + 1) % 65536;
         end
         mv = 1;
      end
   end

   task automatic check(input bit ok, input string req, input longint act,
                        input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic compare_all();
      longint st_c, st_exp;
      st_c   = {i_c, val_c, o_c};
      st_exp = {mn[IW-1:0], mv, mo};
      check(v_c == mf[W-1:0], tag, v_c, mf);
      check(st_c == st_exp, tag, st_c, st_exp);
      check({v_f, i_f, val_f, o_f} == {v_c, i_c, val_c, o_c}, "R10",
            {i_f, val_f, o_f}, {i_c, val_c, o_c});
      if (default_run && val_c)   // R4: closed form n*n+n+41
         check(v_c == W'(mn * mn + mn + 41), "R4", v_c, mn * mn + mn + 41);
   endtask

   task automatic cyc(input bit s);
      @(negedge clk);
      compare_all();
      step = s;
   endtask

   initial begin : watchdog
      #(8 * 20000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      // R1 reset with step held high (R5 also: ignored while invalid)
      step = 1'b1;
      @(posedge clk);
      repeat (3) cyc(1'b1);
      tag = "R5";
      rst = 1'b0;
      cyc(1'b1);                       // valid rises, no advance
      tag = "R2";
      cyc(1'b1);
      // R4/R3: long default run with idle gaps (R6)
      for (int k = 0; k < 130; k++) begin
         tag = (k % 7 == 3) ? "R6" : "R3";
         cyc((k % 7) != 3);
      end
      // Explicit early sequence after a fresh reset: 41 43 47 53 61
      rst = 1'b1;
      tag = "R1";
      cyc(1'b0);
      rst = 1'b0;
      cyc(1'b1);
      tag = "R4";
      for (int k = 0; k < 5; k++) cyc(1'b1);
      default_run = 1'b0;
      // R7: load overrides step; value wraps (R8), sticky (R9)
      tag = "R7";
      lv = 32'hFFFF_FFF0; ld1 = 0; ld2 = 8; load = 1'b1;
      cyc(1'b1);
      load = 1'b0;
      tag = "R2";
      cyc(1'b1);
      tag = "R8";
      for (int k = 0; k < 4; k++) cyc(1'b1);
      tag = "R9";
      for (int k = 0; k < 4; k++) cyc(k % 2 == 0);
      // R8: difference addition alone carries
      tag = "R7";
      lv = 5; ld1 = 32'h8000_0000; ld2 = 32'h8000_0000; load = 1'b1;
      cyc(1'b0);
      load = 1'b0;
      cyc(1'b1);
      tag = "R8";
      for (int k = 0; k < 3; k++) cyc(1'b1);
      // R7: load clears overflow, linear sequence
      tag = "R7";
      lv = 100; ld1 = 3; ld2 = 0; load = 1'b1;
      cyc(1'b1);
      load = 1'b0;
      tag = "R3";
      for (int k = 0; k < 10; k++) cyc(1'b1);
      // Back-to-back loads keep valid low
      tag = "R2";
      lv = 7; ld1 = 1; ld2 = 1; load = 1'b1;
      cyc(1'b1);
      cyc(1'b1);
      load = 1'b0;
      for (int k = 0; k < 4; k++) cyc(1'b1);
      @(negedge clk);
      compare_all();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule